// File: doc/BRIEF.md
# Queued-Sample Pulse-Width Modulator

The block produces one pulse-width-modulated output from a period counter and a queue of duty-cycle samples. Software writes a period value and pushes duty samples into a four-deep queue. The counter runs on a prescaled clock enable. At the end of each period, the block takes the next sample from the queue. Each sample can be replayed 1, 2, 4 or 8 times before the next one is fetched. When the queue runs dry, the block keeps the last sample, so the waveform never glitches for lack of data.

Four 32-bit registers sit on a simple single-cycle write port with a combinational read port: control, status, sample and period. There are three counter clock sources. Each is a clock-enable strobe in the block's own clock domain, and a control field picks one or turns counting off. The output can be driven straight, driven inverted or held low. A self-clearing soft reset returns every register to its reset value and empties the queue.

Top module: `pwm_gen`

## Requirements
- R1: Registers decode at control 0x00, status 0x04, sample 0x0C and period 0x10. Any other offset reads 0. After reset, control reads 0, status reads 0x8 and period reads 0xFFFE.
- R2: One output period spans the period register value plus 2 counter ticks. A stored value of 0xFFFF times exactly like 0xFFFE. Each period end sets status bit 4.
- R3: A counter tick occurs every divide-field-plus-1 strobes of the selected source. The divide field is control[15:4]. Control[17:16] selects the source: 0 stops counting, and 1, 2 or 3 select tick_src_i bit 0, 1 or 2.
- R4: The output is active while the counter (0 at period start) is below the current sample. A sample of 0 gives a constant inactive output. A sample of at least the period value plus 2 gives a constant active output.
- R5: Writes to the sample register queue up to 4 entries. Status[2:0] holds the entry count and status bit 3 flags an empty queue. In the first enabled cycle the block loads the head entry. Later loads happen at period ends once the repeat count is used up. With an empty queue the last sample is kept.
- R6: Control[2:1] values 0, 1, 2 and 3 use each sample for 1, 2, 4 and 8 periods.
- R7: A sample write while 4 entries are queued is discarded and sets status bit 6.
- R8: Status bit 5 sets on the tick at which the counter reaches a nonzero current sample. Writing 1 to status bit 4, 5 or 6 clears that bit; a same-cycle set wins.
- R9: Control[19:18] selects the output mode: 0 drives the output straight, 1 drives it inverted, and 2 or 3 hold it low.
- R10: While control bit 0 (enable) is clear, the output is 0, the counter holds at 0 and the sample register reads 0.
- R11: Writing 1 to control bit 3 sets it for one cycle and leaves the other control fields unchanged. In the next cycle every register and the queue return to their reset values and the bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Byte offset for write and read |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data at reg_addr_i |
| tick_src_i | input | 3 | Three counter clock-enable strobes |
| pwm_o | output | 1 | Modulated output |

## Verification
The main path is driven under three tick patterns: a strobe every cycle, a strobe every other cycle and a strobe every third cycle. Each pattern is combined with divide ratios of 1 and 2. Together these separate prescaler counting from source selection and show whether a counter that pauses between strobes still holds its place. The sample sequences mix values below the period, 0 and values above the period. This separates the compare edge from the two constant-output cases. Repeat settings of 1, 2 and 8 show whether queue pops follow the repeat limit or every period end. A run with the period register at 0xFFFF, timed to the exact rollover cycle, tells the clamped period apart from an unclamped one.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
  localparam int unsigned REG_AW = 5;
  localparam logic [REG_AW-1:0] OFF_CTRL = 5'h00;
  localparam logic [REG_AW-1:0] OFF_STAT = 5'h04;
  localparam logic [REG_AW-1:0] OFF_SMP  = 5'h0C;
  localparam logic [REG_AW-1:0] OFF_PER  = 5'h10;

  localparam int unsigned CTL_EN  = 0;
  localparam int unsigned CTL_REP = 1;
  localparam int unsigned CTL_SWR = 3;
  localparam int unsigned CTL_DIV = 4;
  localparam int unsigned CTL_SRC = 16;
  localparam int unsigned CTL_OUT = 18;

  localparam int unsigned ST_EMPTY = 3;
  localparam int unsigned ST_ROV   = 4;
  localparam int unsigned ST_CMP   = 5;
  localparam int unsigned ST_WERR  = 6;

  typedef enum logic [1:0] {
    OUT_STRAIGHT = 2'd0,
    OUT_INVERT   = 2'd1,
    OUT_LOW_A    = 2'd2,
    OUT_LOW_B    = 2'd3
  } out_mode_e;
endpackage

// File: rtl/pwm_gen_fifo.sv
module pwm_gen_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;
  assign rdata_o = mem_q[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  assert_count_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_no_pop_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/pwm_gen_timebase.sv
module pwm_gen_timebase #(
  parameter int unsigned DIV_W = 12,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [CNT_W-1:0] last_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             step_o,
  output logic             roll_o
);
  logic [DIV_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;

  assign step_o = ~clr_i & tick_i & (pre_q >= div_i);
  // >= so a period shortened mid-count still wraps
  assign roll_o = step_o & (cnt_q >= last_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (tick_i) begin
      if (pre_q >= div_i) begin
        pre_q <= '0;
        cnt_q <= roll_o ? '0 : cnt_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assert_roll_wraps_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    roll_o |=> (cnt_o == '0));
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_gen_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DIV_W = 12,
  parameter int unsigned REP_W = 2,
  parameter int unsigned SRC_W = 2,
  localparam int unsigned NSRC = (1 << SRC_W) - 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned RCW  = (1 << REP_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [NSRC-1:0]   tick_src_i,
  output logic              pwm_o
);
  localparam logic [CNT_W-1:0] PER_RST = {{(CNT_W-1){1'b1}}, 1'b0};

  logic             en_q, swr_q, ld_q;
  logic [REP_W-1:0] rep_q;
  logic [DIV_W-1:0] div_q;
  logic [SRC_W-1:0] src_q;
  out_mode_e        outc_q;
  logic [CNT_W-1:0] per_q, cur_q;
  logic [RCW-1:0]   repc_q, rep_lim;
  logic             rov_q, cmp_q, werr_q;

  logic             run, tick, step, roll, pop, cmp_evt, rep_done, act;
  logic             wr_ctrl, wr_stat, wr_smp, wr_per;
  logic [CNT_W-1:0] per_eff, last, cnt;
  logic [CNT_W-1:0] fifo_rdata;
  logic [CW-1:0]    fifo_cnt;
  logic             fifo_full, fifo_empty;

  assign run     = en_q & ~swr_q;
  assign wr_ctrl = reg_we_i & (reg_addr_i == OFF_CTRL) & ~swr_q;
  assign wr_stat = reg_we_i & (reg_addr_i == OFF_STAT) & ~swr_q;
  assign wr_smp  = reg_we_i & (reg_addr_i == OFF_SMP)  & ~swr_q;
  assign wr_per  = reg_we_i & (reg_addr_i == OFF_PER)  & ~swr_q;

  assign tick    = (src_q != '0) ? tick_src_i[src_q - 1'b1] : 1'b0;
  // all-ones period times as all-ones minus one
  assign per_eff = (per_q == '1) ? per_q - 1'b1 : per_q;
  assign last    = per_eff + 1'b1;

  always_comb begin
    rep_lim = '0;
    for (int i = 0; i < RCW; i++) rep_lim[i] = (rep_q > REP_W'(i));
  end

  assign rep_done = (repc_q == rep_lim);
  assign pop      = run & ~fifo_empty & (ld_q | (roll & rep_done));
  assign cmp_evt  = step & ~roll & ((cnt + 1'b1) == cur_q);

  pwm_gen_timebase #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_tb (
    .clk_i (clk_i),  .rst_ni (rst_ni), .clr_i (~run), .tick_i (tick),
    .div_i (div_q),  .last_i (last),   .cnt_o (cnt),  .step_o (step),
    .roll_o(roll)
  );

  pwm_gen_fifo #(.DEPTH(DEPTH), .DW(CNT_W)) u_fifo (
    .clk_i  (clk_i),    .rst_ni (rst_ni), .flush_i(swr_q),
    .push_i (wr_smp),   .wdata_i(reg_wdata_i[CNT_W-1:0]),
    .pop_i  (pop),      .rdata_o(fifo_rdata), .count_o(fifo_cnt),
    .full_o (fifo_full),.empty_o(fifo_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; swr_q <= 1'b0; ld_q <= 1'b1; rep_q <= '0; div_q <= '0;
      src_q <= '0; outc_q <= OUT_STRAIGHT; per_q <= PER_RST; cur_q <= '0;
      repc_q <= '0; rov_q <= 1'b0; cmp_q <= 1'b0; werr_q <= 1'b0;
    end else if (swr_q) begin
      en_q <= 1'b0; swr_q <= 1'b0; ld_q <= 1'b1; rep_q <= '0; div_q <= '0;
      src_q <= '0; outc_q <= OUT_STRAIGHT; per_q <= PER_RST; cur_q <= '0;
      repc_q <= '0; rov_q <= 1'b0; cmp_q <= 1'b0; werr_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        if (reg_wdata_i[CTL_SWR]) begin
          swr_q <= 1'b1;
        end else begin
          en_q   <= reg_wdata_i[CTL_EN];
          rep_q  <= reg_wdata_i[CTL_REP +: REP_W];
          div_q  <= reg_wdata_i[CTL_DIV +: DIV_W];
          src_q  <= reg_wdata_i[CTL_SRC +: SRC_W];
          outc_q <= out_mode_e'(reg_wdata_i[CTL_OUT +: 2]);
        end
      end
      if (wr_per) per_q <= reg_wdata_i[CNT_W-1:0];
      ld_q <= ~run;
      if (!run)      repc_q <= '0;
      else if (roll) repc_q <= rep_done ? '0 : repc_q + 1'b1;
      if (pop) cur_q <= fifo_rdata;
      rov_q  <= (rov_q  & ~(wr_stat & reg_wdata_i[ST_ROV]))  | roll;
      cmp_q  <= (cmp_q  & ~(wr_stat & reg_wdata_i[ST_CMP]))  | cmp_evt;
      werr_q <= (werr_q & ~(wr_stat & reg_wdata_i[ST_WERR])) | (wr_smp & fifo_full);
    end
  end

  assign act = (cnt < cur_q);
  always_comb begin
    unique case (outc_q)
      OUT_STRAIGHT: pwm_o = run & act;
      OUT_INVERT:   pwm_o = run & ~act;
      default:      pwm_o = 1'b0;
    endcase
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFF_CTRL: begin
        reg_rdata_o[CTL_EN]              = en_q;
        reg_rdata_o[CTL_REP +: REP_W]    = rep_q;
        reg_rdata_o[CTL_SWR]             = swr_q;
        reg_rdata_o[CTL_DIV +: DIV_W]    = div_q;
        reg_rdata_o[CTL_SRC +: SRC_W]    = src_q;
        reg_rdata_o[CTL_OUT +: 2]        = outc_q;
      end
      OFF_STAT: begin
        reg_rdata_o[CW-1:0]   = fifo_cnt;
        reg_rdata_o[ST_EMPTY] = fifo_empty;
        reg_rdata_o[ST_ROV]   = rov_q;
        reg_rdata_o[ST_CMP]   = cmp_q;
        reg_rdata_o[ST_WERR]  = werr_q;
      end
      OFF_SMP:  reg_rdata_o[CNT_W-1:0] = run ? cur_q : '0;
      OFF_PER:  reg_rdata_o[CNT_W-1:0] = per_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assert_swr_selfclear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swr_q |=> !swr_q);
  assert_full_write_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_smp && fifo_full) |=> werr_q);
  assert_pop_loads_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |=> (cur_q == $past(fifo_rdata)));
  assert_repeat_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (roll && !rep_done) |=> $stable(cur_q));
endmodule

// File: tb/pwm_gen_tb.sv
module pwm_gen_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = 5'h0;
  logic [31:0] wdata = 32'h0;
  logic [2:0]  tick_src = 3'b001;
  logic [31:0] rdata;
  logic        pwm;
  int checks = 0, fails = 0, tcyc = 0;
  bit done = 1'b0;

  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_SMP = 5'h0C, A_PER = 5'h10;

  always #4 clk = ~clk;  // 125 MHz

  pwm_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tick_src_i(tick_src), .pwm_o(pwm)
  );

  // strobes: every cycle, every other cycle, every third cycle
  always @(posedge clk) begin
    tcyc++;
    #1 tick_src = {(tcyc % 3) == 0, tcyc[0], 1'b1};
  end

  // ---------------- behavioural reference ----------------
  logic [15:0] q[$];
  bit          m_en, m_swr, m_ld, m_rov, m_cmp, m_werr;
  int          m_rep, m_div, m_src, m_outc, m_per, m_cur, m_pre, m_cnt, m_repc;

  task automatic m_reset();
    q.delete();
    m_en = 0; m_swr = 0; m_ld = 1; m_rov = 0; m_cmp = 0; m_werr = 0;
    m_rep = 0; m_div = 0; m_src = 0; m_outc = 0; m_per = 'hFFFE;
    m_cur = 0; m_pre = 0; m_cnt = 0; m_repc = 0;
  endtask

  task automatic m_step();
    int pe, lim;
    bit tk, stp, rl, cm, full, pp, stw;
    if (m_swr) begin m_reset(); return; end
    pe   = (m_per == 'hFFFF) ? 'hFFFE : m_per;
    tk   = (m_src != 0) && tick_src[m_src-1];
    stp  = m_en && tk && (m_pre >= m_div);
    rl   = stp && (m_cnt >= pe + 1);
    cm   = stp && !rl && (m_cnt + 1 == m_cur);
    lim  = (1 << m_rep) - 1;
    full = (q.size() == 4);
    pp   = m_en && (q.size() > 0) && (m_ld || (rl && m_repc == lim));
    if (!m_en) begin m_pre = 0; m_cnt = 0; end
    else if (tk) begin
      if (m_pre >= m_div) begin m_pre = 0; m_cnt = rl ? 0 : m_cnt + 1; end
      else m_pre++;
    end
    if (!m_en) m_repc = 0;
    else if (rl) m_repc = (m_repc == lim) ? 0 : m_repc + 1;
    m_ld = !m_en;
    if (pp) m_cur = q.pop_front();
    stw = we && addr == A_STAT;
    m_rov  = (m_rov  && !(stw && wdata[4])) || rl;
    m_cmp  = (m_cmp  && !(stw && wdata[5])) || cm;
    m_werr = (m_werr && !(stw && wdata[6])) || (we && addr == A_SMP && full);
    if (we && addr == A_SMP && !full) q.push_back(wdata[15:0]);
    if (we && addr == A_PER) m_per = wdata[15:0];
    if (we && addr == A_CTRL) begin
      if (wdata[3]) m_swr = 1;
      else begin
        m_en = wdata[0]; m_rep = wdata[2:1]; m_div = wdata[15:4];
        m_src = wdata[17:16]; m_outc = wdata[19:18];
      end
    end
  endtask

  function automatic logic [31:0] m_rd(input logic [4:0] a);
    bit run = m_en && !m_swr;
    case (a)
      A_CTRL: return {12'h0, 2'(m_outc), 2'(m_src), 12'(m_div), m_swr, 2'(m_rep), m_en};
      A_STAT: return {25'h0, m_werr, m_cmp, m_rov, q.size() == 0, 3'(q.size())};
      A_SMP:  return run ? 32'(m_cur) : 32'h0;
      A_PER:  return 32'(m_per);
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic m_pwm();
    bit run = m_en && !m_swr;
    bit act = m_cnt < m_cur;
    if (!run) return 1'b0;
    if (m_outc == 0) return act;
    if (m_outc == 1) return !act;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else m_step();
  end

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks += 2;
      if (pwm !== m_pwm()) begin
        fails++;
        $display("FAIL R2/R3/R4/R6/R9/R10 pwm_o t=%0t act=%0b exp=%0b", $time, pwm, m_pwm());
      end
      if (rdata !== m_rd(addr)) begin
        fails++;
        $display("FAIL R1/R5/R8 rdata @%0h t=%0t act=%0h exp=%0h", addr, $time, rdata, m_rd(addr));
      end
    end
  end

  // ---------------- directed checks ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    we = 1'b0; wdata = 32'h0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] mask,
                    input logic [31:0] exp, input string tag);
    addr = a; #2;
    chk(tag, rdata & mask, exp);
    @(posedge clk); #2;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pwm_hold(input logic v, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); chk(tag, 32'(pwm), 32'(v));
    end
    @(posedge clk); #2;
  endtask

  task automatic summary();
    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    cyc(1);
    rd(A_CTRL, 32'hFFFFFFFF, 32'h0,     "R1 ctrl reset");
    rd(A_STAT, 32'hFFFFFFFF, 32'h8,     "R1 status reset");
    rd(A_PER,  32'hFFFFFFFF, 32'hFFFE,  "R1 period reset");
    rd(5'h08,  32'hFFFFFFFF, 32'h0,     "R1 unmapped offset");
    rd(A_SMP,  32'hFFFFFFFF, 32'h0,     "R10 sample while disabled");

    wr(A_SMP, 2); wr(A_SMP, 1); wr(A_SMP, 6);
    rd(A_STAT, 32'hF, 32'h3, "R5 count three");
    wr(A_SMP, 4);
    rd(A_STAT, 32'hFF, 32'h04, "R5 count four");
    wr(A_SMP, 9);
    rd(A_STAT, 32'hFF, 32'h44, "R7 full write dropped");
    wr(A_STAT, 32'h40);
    rd(A_STAT, 32'hFF, 32'h04, "R8 w1c write error");

    wr(A_PER, 3);
    wr(A_CTRL, 32'h0001_0001);
    cyc(40);
    rd(A_STAT, 32'h3F, 32'h38, "R2 R8 rollover compare empty");
    wr(A_SMP, 9);
    cyc(12);
    rd(A_SMP, 32'hFFFF, 32'h9, "R5 sample loaded");
    pwm_hold(1'b1, 12, "R4 sample above period");
    wr(A_SMP, 0);
    cyc(12);
    pwm_hold(1'b0, 12, "R4 zero sample");
    cyc(10);
    rd(A_SMP, 32'hFFFF, 32'h0, "R5 last sample reused");

    wr(A_CTRL, 32'h0001_0000);
    pwm_hold(1'b0, 5, "R10 disabled output");
    rd(A_SMP, 32'hFFFFFFFF, 32'h0, "R10 sample reads zero");

    wr(A_PER, 6);
    wr(A_SMP, 3); wr(A_SMP, 5); wr(A_SMP, 1);
    wr(A_CTRL, 32'h0006_0013);   // src 2, div 2, repeat x2, inverted
    cyc(200);
    wr(A_SMP, 2); wr(A_SMP, 7); wr(A_SMP, 4);
    wr(A_CTRL, 32'h0007_0017);   // src 3, repeat x8
    cyc(300);
    wr(A_CTRL, 32'h0004_0013);   // src off: counter frozen
    cyc(30);
    wr(A_CTRL, 32'h000A_0013);   // output held low
    pwm_hold(1'b0, 20, "R9 output mode low");

    wr(A_CTRL, 32'h0000_0008);
    addr = A_CTRL; #2;
    chk("R11 reset bit visible", 32'(rdata[3]), 32'h1);
    @(posedge clk); #2;
    rd(A_CTRL, 32'hFFFFFFFF, 32'h0,    "R11 ctrl cleared");
    rd(A_STAT, 32'hFFFFFFFF, 32'h8,    "R11 queue flushed");
    rd(A_PER,  32'hFFFFFFFF, 32'hFFFE, "R11 period reset");

    wr(A_PER, 32'hFFFF);
    wr(A_CTRL, 32'h0001_0001);
    repeat (65535) @(posedge clk);
    #2;
    rd(A_STAT, 32'hFF, 32'h08, "R2 no rollover before 0x10000 ticks");
    rd(A_STAT, 32'hFF, 32'h18, "R2 rollover at clamped period");
    rd(A_PER, 32'hFFFF, 32'hFFFF, "R1 period stores raw value");
    summary();
  end
endmodule